// File: doc/BRIEF.md
# Two-Error Serial BCH(15,7) Decoder

This block receives words of the systematic binary BCH code of length 15, one bit per clock, and repairs up to two flipped bits in each word. The code has 7 message bits and 8 check bits, and its generator polynomial is x^8+x^7+x^6+x^4+1. The decoder uses one 15-bit circulating buffer and one 8-bit remainder register. Each word takes three passes of 15 clocks:

- **Load pass.** The word is shifted into the buffer while its remainder modulo the generator is formed.
- **First repair pass.** The buffer rotates once with its feedback closed. A detector watches the remainder as it shifts and flips at most one bit.
- **Second repair pass.** The buffer rotates a second time and at most one more bit is flipped. The remainder is updated after every flip.

At the end of the second repair pass the message bits are presented in parallel with a one-cycle valid strobe.

The upstream source sees a ready signal. Ready is high only during the load pass, so the source waits 30 clocks after the last bit of each word. A word still carries a nonzero remainder after both repair passes when it lies further than two bit flips from every codeword. In that case the word is flagged as uncorrectable, and the message bits are returned exactly as they were received.

Top module: `bch2_serial_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, inReady is 1, outValid is 0 and uncorrectable is 0.
- R2: A word that is an exact codeword is output unchanged on dataOut, with uncorrectable 0.
- R3: A word with any single bit flipped, at any of the 15 positions, is output with its original 7 message bits and uncorrectable 0.
- R4: A word with any two distinct bits flipped is output with its original message bits and uncorrectable 0.
- R5: A word whose Hamming distance to every codeword exceeds 2 is output with uncorrectable 1. Its dataOut equals the first 7 bits received, unmodified.
- R6: After the clock edge that accepts the 15th bit of a word, inReady is 0 for exactly 30 cycles and then returns to 1.
- R7: A bit is taken only on an edge where inValid and inReady are both 1. Idle cycles with inValid 0 in the middle of a word do not change the result.
- R8: outValid is a one-cycle pulse that rises on the same edge at which inReady returns to 1. uncorrectable is 1 only in a cycle where outValid is 1.
- R9: Bit order and layout are as follows:
  - The first bit received is the coefficient of x^14.
  - Received bits 1 to 7 are the message, and the first of them is dataOut[6].
  - The last 8 bits are the remainder of message·x^8 divided by the generator, highest coefficient first.
- R10: inBit and inValid are ignored while inReady is 0. A word sent after busy cycles in which inValid was 1 with random inBit values decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inBit | input | 1 | Serial received bit, highest coefficient first |
| inValid | input | 1 | inBit holds a bit to be taken |
| inReady | output | 1 | Decoder is in its load pass and takes a bit this cycle |
| dataOut | output | 7 | Decoded message bits, valid with outValid |
| outValid | output | 1 | One-cycle pulse marking a decoded word |
| uncorrectable | output | 1 | The word could not be repaired; dataOut holds the raw message bits |

## Verification
The bound checker checks the handshake timing on every cycle:

- the 30-cycle busy window;
- that the busy window is entered only after an accepted bit;
- the single-cycle output pulse and its alignment with the return of ready;
- that the uncorrectable flag never appears without the pulse.

The bench scenarios are the only evidence for correct decoding. The scoreboard compares each output against a nearest-codeword search. The scenarios cover all 128 clean words, every single-bit position, every two-bit pair and words with three or four errors. They also cover idle gaps inside a word and random traffic offered while the decoder is busy.

// File: rtl/bch_dec_pkg.sv
package bch_dec_pkg;

  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_FIX_A = 2'd1,
    ST_FIX_B = 2'd2
  } bchState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;    // accept one received bit
    logic lastIn;     // this accepted bit completes the word
    logic fixStep;    // one rotation step of a repair pass
    logic passStart;  // first step of a repair pass
    logic finish;     // last step of the second repair pass
  } bchStrobes_t;

endpackage

// File: rtl/bch_dec_ctrl.sv
module bch_dec_ctrl
  import bch_dec_pkg::*;
#(
  parameter int N = 15
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  output bchStrobes_t ctl
);

  localparam int CW = $clog2(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  bchState_t state;
  logic [CW-1:0] cnt;
  logic atLast;

  assign atLast  = (cnt == LAST);
  assign inReady = (state == ST_LOAD);

  always_comb begin
    ctl.shiftIn   = (state == ST_LOAD) && inValid;
    ctl.lastIn    = ctl.shiftIn && atLast;
    ctl.fixStep   = (state != ST_LOAD);
    ctl.passStart = ctl.fixStep && (cnt == '0);
    ctl.finish    = (state == ST_FIX_B) && atLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_LOAD;
      cnt   <= '0;
    end else begin
      if (ctl.shiftIn || ctl.fixStep) begin
        cnt <= atLast ? '0 : cnt + 1'b1;
      end
      unique case (state)
        ST_LOAD:  if (ctl.lastIn) state <= ST_FIX_A;
        ST_FIX_A: if (atLast)     state <= ST_FIX_B;
        ST_FIX_B: if (atLast)     state <= ST_LOAD;
        default:                  state <= ST_LOAD;
      endcase
    end
  end

endmodule

// File: rtl/bch_dec_datapath.sv
module bch_dec_datapath
  import bch_dec_pkg::*;
#(
  parameter int N = 15,
  parameter int P = 8,
  parameter logic [P:0] GEN = 9'h1D1
) (
  input  logic           clk,
  input  logic           rstN,
  input  bchStrobes_t    ctl,
  input  logic           inBit,
  output logic [N-P-1:0] dataOut,
  output logic           outValid,
  output logic           uncorrectable
);

  localparam int K = N - P;

  // x^e mod generator
  function automatic logic [P-1:0] xPowMod(input int e);
    logic [P-1:0] v;
    v = {{(P-1){1'b0}}, 1'b1};
    for (int i = 0; i < e; i++) begin
      v = {v[P-2:0], 1'b0} ^ (v[P-1] ? GEN[P-1:0] : '0);
    end
    return v;
  endfunction

  localparam logic [P-1:0] LEAD_SYN = xPowMod(N - 1);

  logic [P-1:0] syn, synCorr, synNext;
  logic [N-1:0] word, wordNext;
  logic [K-1:0] rawData;
  logic [N-1:0] hitVec;
  logic fixedFlag, hit, fixNow, synLeft;

  // error patterns containing the leading position: alone, or with one other bit
  assign hitVec[N-1] = (syn == LEAD_SYN);
  for (genvar j = 0; j < N - 1; j++) begin : g_pair
    localparam logic [P-1:0] PAT = LEAD_SYN ^ xPowMod(j);
    assign hitVec[j] = (syn == PAT);
  end

  assign hit    = |hitVec;
  assign fixNow = ctl.fixStep && hit && (ctl.passStart || !fixedFlag);

  always_comb begin
    synNext  = syn;
    wordNext = word;
    synCorr  = syn ^ (fixNow ? LEAD_SYN : '0);
    if (ctl.shiftIn) begin
      synNext  = {syn[P-2:0], inBit} ^ (syn[P-1] ? GEN[P-1:0] : '0);
      wordNext = {word[N-2:0], inBit};
    end else if (ctl.fixStep) begin
      synNext  = {synCorr[P-2:0], 1'b0} ^ (synCorr[P-1] ? GEN[P-1:0] : '0);
      wordNext = {word[N-2:0], word[N-1] ^ fixNow};
    end
  end

  assign synLeft = |synNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syn           <= '0;
      word          <= '0;
      rawData       <= '0;
      fixedFlag     <= 1'b0;
      dataOut       <= '0;
      outValid      <= 1'b0;
      uncorrectable <= 1'b0;
    end else begin
      syn  <= ctl.finish ? '0 : synNext;
      word <= wordNext;
      if (ctl.lastIn) rawData <= wordNext[N-1:P];
      if (ctl.fixStep) fixedFlag <= ctl.passStart ? fixNow : (fixedFlag | fixNow);
      outValid      <= ctl.finish;
      uncorrectable <= ctl.finish && synLeft;
      if (ctl.finish) dataOut <= synLeft ? rawData : wordNext[N-1:P];
    end
  end

endmodule

// File: rtl/bch2_serial_decoder.sv
module bch2_serial_decoder
  import bch_dec_pkg::*;
#(
  parameter int N = 15,
  parameter int P = 8,
  parameter logic [P:0] GEN = 9'h1D1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inBit,
  input  logic           inValid,
  output logic           inReady,
  output logic [N-P-1:0] dataOut,
  output logic           outValid,
  output logic           uncorrectable
);

  bchStrobes_t ctl;

  bch_dec_ctrl #(.N(N)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inReady (inReady),
    .ctl     (ctl)
  );

  bch_dec_datapath #(.N(N), .P(P), .GEN(GEN)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .inBit         (inBit),
    .dataOut       (dataOut),
    .outValid      (outValid),
    .uncorrectable (uncorrectable)
  );

endmodule

// File: rtl/bch2_serial_decoder_chk.sv
module bch2_serial_decoder_chk #(
  parameter int N = 15
) (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic inReady,
  input logic outValid,
  input logic uncorrectable
);

  int busyLen;

  always_ff @(posedge clk) begin
    if (!rstN) busyLen <= 0;
    else if (!inReady) busyLen <= busyLen + 1;
    else busyLen <= 0;
  end

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inReady) |-> busyLen == 2 * N);

  // R6
  busy_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |-> busyLen < 2 * N);

  // R7
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inReady) |-> $past(inValid));

  // R8
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R8
  out_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> inReady && $past(!inReady));

  // R8
  flag_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    uncorrectable |-> outValid);

endmodule

bind bch2_serial_decoder bch2_serial_decoder_chk #(.N(N)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .inValid       (inValid),
  .inReady       (inReady),
  .outValid      (outValid),
  .uncorrectable (uncorrectable)
);

// File: tb/bch2_serial_decoder_test.sv
module bch2_serial_decoder_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inBit = 1'b0;
  logic inValid = 1'b0;
  logic inReady, outValid, uncorrectable;
  logic [6:0] dataOut;

  always #4 clk = ~clk;  // 125 MHz

  bch2_serial_decoder uut (
    .clk(clk), .rstN(rstN), .inBit(inBit), .inValid(inValid),
    .inReady(inReady), .dataOut(dataOut), .outValid(outValid),
    .uncorrectable(uncorrectable)
  );

  typedef struct {
    logic [6:0] data;
    logic       unc;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  int lowRun = 0;
  bit done = 0;

  // R9: message first, then remainder of m*x^8 by the generator
  function automatic logic [14:0] encode(input logic [6:0] m);
    logic [7:0] r;
    logic b, fb;
    r = '0;
    for (int i = 14; i >= 0; i--) begin
      b  = (i >= 8) ? m[i-8] : 1'b0;
      fb = r[7];
      r  = {r[6:0], b} ^ (fb ? 8'hD1 : 8'h00);
    end
    return {m, r};
  endfunction

  function automatic exp_t reference(input logic [14:0] w, input string tag);
    exp_t e;
    e.data = w[14:8];
    e.unc  = 1'b1;
    e.tag  = tag;
    for (int m = 0; m < 128; m++) begin
      if ($countones(encode(7'(m)) ^ w) <= 2) begin
        e.data = 7'(m);
        e.unc  = 1'b0;
      end
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  // driver: pushes the expected result, then offers the bits
  task automatic sendWord(input logic [14:0] w, input int gapPct, input string tag);
    bit sent;
    q.push_back(reference(w, tag));
    for (int i = 14; i >= 0; i--) begin
      sent = 0;
      while (!sent) begin
        @(negedge clk);
        if (inReady) begin
          if ($urandom_range(99) < gapPct) begin
            inValid = 1'b0;   // R7 idle gap
            inBit   = 1'($urandom);
          end else begin
            inValid = 1'b1;
            inBit   = w[i];
            sent    = 1;
          end
        end else begin
          inValid = 1'b1;     // R10 junk while busy
          inBit   = 1'($urandom);
        end
      end
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (uncorrectable && !outValid)
        check(0, $sformatf("R8: uncorrectable %b without outValid, expected 0", uncorrectable));
      if (outValid) begin
        if (q.size() == 0) begin
          check(0, "R8: outValid 1 with no word pending, expected 0");
        end else begin
          exp_t e;
          e = q.pop_front();
          check(dataOut == e.data && uncorrectable == e.unc,
                $sformatf("%s: data %h unc %b, expected data %h unc %b",
                          e.tag, dataOut, uncorrectable, e.data, e.unc));
        end
      end
      if (!inReady) begin
        lowRun++;
      end else if (lowRun > 0) begin
        check(lowRun == 30, $sformatf("R6: busy run %0d, expected 30", lowRun));
        check(outValid, $sformatf("R8: outValid %b when ready returns, expected 1", outValid));
        lowRun = 0;
      end
    end
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run hung, %0d words pending, expected 0", q.size());
    done = 1;
    finishRun();
  end

  initial begin
    logic [14:0] w;
    int a, b, c;

    repeat (3) @(negedge clk);
    check(inReady == 1 && outValid == 0 && uncorrectable == 0,
          $sformatf("R1: in reset ready %b valid %b unc %b, expected 1 0 0",
                    inReady, outValid, uncorrectable));
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1 && outValid == 0 && uncorrectable == 0,
          $sformatf("R1: after reset ready %b valid %b unc %b, expected 1 0 0",
                    inReady, outValid, uncorrectable));

    sendWord(encode(7'h40), 0, "R9");
    sendWord(encode(7'h01), 0, "R9");

    for (int m = 0; m < 128; m++)
      sendWord(encode(7'(m)), (m % 4 == 0) ? 40 : 0, (m % 4 == 0) ? "R7" : "R2");

    foreach (q[i]) ;  // keep queue usage plain
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 15; p++)
        sendWord(encode(7'(m * 37 + 5)) ^ (15'd1 << p), 10, "R3");

    for (int p = 0; p < 15; p++)
      for (int s = p + 1; s < 15; s++)
        sendWord(encode(7'h5A) ^ (15'd1 << p) ^ (15'd1 << s), 0, "R4");

    for (int n = 0; n < 30; n++) begin
      a = $urandom_range(14);
      b = (a + 1 + $urandom_range(12)) % 15;
      c = $urandom_range(14);
      while (c == a || c == b) c = $urandom_range(14);
      w = encode(7'($urandom)) ^ (15'd1 << a) ^ (15'd1 << b) ^ (15'd1 << c);
      sendWord(w, 0, "R5");
    end
    sendWord(encode(7'h33) ^ 15'h000F, 0, "R5");
    sendWord(encode(7'h2C) ^ 15'h4801, 20, "R10");
    sendWord(encode(7'h7F), 0, "R10");

    @(negedge clk);
    inValid = 1'b0;
    repeat (40) @(negedge clk);
    check(q.size() == 0, $sformatf("R8: %0d words without output, expected 0", q.size()));
    done = 1;
    finishRun();
  end

endmodule